// File: doc/BRIEF.md
# Remappable Priority Interrupt Encoder

This block picks one winner among the pending interrupt requests of a group of communication channels, timers and external lines. It reports that winner as a 7-bit vector code equal to the winner's level in a priority table, where level 1 is the most urgent. Most sources do not have a fixed level. Software assigns each of them to a movable slot through two mapping registers. Those registers may be rewritten at any moment, so software can rotate priority among peer channels.

There are three slot families of eight slots each. Serial channels use the Y slots. Fast channels and the multichannel controller use the X slots. Five external lines and two timers use the general (G) slots. A placement mode decides where the Y slots sit in the table. In the grouped layout they form one contiguous run near the top. In the spread layout they are interleaved with the other sources. A lock bit freezes the placement mode. A promotion option lifts one chosen source above every other entry. The vector output is registered, one clock after the requests are sampled.

Top module: `irq_prio_encoder`

## Requirements
- R1: `vec` and `vec_vld` are registered and reflect the requests sampled at the previous rising clock edge. When no effective request is pending, `vec_vld` is 0 and `vec` is 0.
- R2: Among the pending effective sources, the one with the numerically smallest level wins, and `vec` equals that level. Every valid code lies in 1..31.
- R3: Request bits and grouped layout. Bits 3:0 are serial channels Y-class 0..3. Bits 7:4 are fast channels X-class 0..3. Bits 14:8 are general sources G-class 0..6: external lines 1..5, then the periodic timer, then the timer counter. The fixed sources are bit 15 external line 6, bit 16 external line 7, bit 17 DMA bus error, bit 18 management channel 1, bit 19 management channel 2, bit 20 parallel pin 1 and bit 21 parallel pin 0. In the grouped layout, X slot k sits at level 1+k and Y slot k at level 9+k. The remaining entries are indexed j: G slot k has j=k and fixed source f (bit 15+f) has j=8+f. Entry j sits at level 17+j.
- R4: In the spread layout, Y slot k sits at level 9+2k. Entry j sits at level 10+2j for j<8 and at level 17+j otherwise. X levels are unchanged.
- R5: Register address 0 holds the slot of Y source k in data bits [3k+2:3k] and the slot of X source k in bits [12+3k+2:12+3k]. Address 1 holds the slot of G source k in bits [3k+2:3k]. A write takes effect for the requests sampled at the next rising edge after the write edge.
- R6: When several sources of one class name the same slot, only the lowest-numbered of them owns the slot. The others never produce a vector.
- R7: Address 2 holds the configuration: bit 0 selects spread (1) or grouped (0), bit 1 is lock, bit 2 enables promotion, and bits 12:8 hold the promoted source's request bit. Once lock is 1, writes leave the spread and lock bits unchanged until reset. The promotion fields stay writable.
- R8: With promotion enabled and the promoted source pending and owning its slot, `vec` is that source's own level, whatever else is pending. A promoted index of 22 or more has no effect.
- R9: After reset the outputs are invalid, every mappable source k uses slot k, the layout is grouped, lock is 0 and promotion is off.
- R10: The seven fixed sources keep their levels under any mapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 Y/X mapping, 1 G mapping, 2 configuration |
| wr_data | input | 32 | Register write data |
| req | input | 22 | Pending request per source |
| vec | output | 7 | Level code of the winning source, 0 when none |
| vec_vld | output | 1 | A winning source exists |

## Verification
The bench sweeps every single-source request in both layouts. A design with a wrong level formula, or a spread interleave shifted by one, shows a wrong code for some source there. A slot collision is set up explicitly: a design that lets the higher-numbered source in, or that drops both, reports a vector when only the loser is pending, or misses the owner. Writes to the locked mode bit are followed by a request whose level differs between the layouts, so a lock that leaks changes the code. Rotation steps and random remaps follow each write on the very next edge, which catches a remap that lands one cycle late.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int SLOT_W  = 3;
  localparam int NSLOT   = 1 << SLOT_W;
  localparam int NY      = 4;
  localparam int NX      = 4;
  localparam int NG      = 7;
  localparam int NFIX    = 7;
  localparam int NSRC    = NY + NX + NG + NFIX;
  localparam int VEC_W   = 7;
  localparam int IDX_W   = 5;
  localparam int Y_BASE  = 0;
  localparam int X_BASE  = NY;
  localparam int G_BASE  = NY + NX;
  localparam int F_BASE  = NY + NX + NG;
  localparam int MAX_LVL = 3 * NSLOT + NFIX;

  // X family: always directly below level 0
  function automatic logic [VEC_W-1:0] lvl_x(input int k);
    return VEC_W'(1 + k);
  endfunction

  // Y family: contiguous or every other level
  function automatic logic [VEC_W-1:0] lvl_y(input int k, input logic sp);
    int v;
    if (sp) v = NSLOT + 1 + 2 * k;
    else    v = NSLOT + 1 + k;
    return VEC_W'(v);
  endfunction

  // Remaining entries (G slots then fixed sources)
  function automatic logic [VEC_W-1:0] lvl_n(input int j, input logic sp);
    int v;
    if (sp && j < NSLOT) v = NSLOT + 2 + 2 * j;
    else                 v = 2 * NSLOT + 1 + j;
    return VEC_W'(v);
  endfunction

  function automatic logic [63:0] ident_map(input int n);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < n; i++) r[i*SLOT_W +: SLOT_W] = SLOT_W'(i % NSLOT);
    return r;
  endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_prio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [1:0]            wr_addr,
  input  logic [31:0]           wr_data,
  output logic [NY*SLOT_W-1:0]  ymap,
  output logic [NX*SLOT_W-1:0]  xmap,
  output logic [NG*SLOT_W-1:0]  gmap,
  output logic                  spread,
  output logic                  lock,
  output logic                  promo_en,
  output logic [IDX_W-1:0]      promo_idx
);
  localparam int YW = NY * SLOT_W;
  localparam int XW = NX * SLOT_W;
  localparam int GW = NG * SLOT_W;
  localparam logic [63:0] ID_Y = ident_map(NY);
  localparam logic [63:0] ID_X = ident_map(NX);
  localparam logic [63:0] ID_G = ident_map(NG);

  logic [YW-1:0]    ymap_q, ymap_d;
  logic [XW-1:0]    xmap_q, xmap_d;
  logic [GW-1:0]    gmap_q, gmap_d;
  logic             spread_q, spread_d, lock_q, lock_d, pen_q, pen_d;
  logic [IDX_W-1:0] pidx_q, pidx_d;
  logic             cfg_ce;
  logic             unused_wr;

  assign unused_wr = ^wr_data;
  assign cfg_ce    = wr_en;

  always_comb begin
    ymap_d   = ymap_q;
    xmap_d   = xmap_q;
    gmap_d   = gmap_q;
    spread_d = spread_q;
    lock_d   = lock_q;
    pen_d    = pen_q;
    pidx_d   = pidx_q;
    if (wr_en) begin
      case (wr_addr)
        2'd0: begin
          ymap_d = wr_data[YW-1:0];
          xmap_d = wr_data[YW +: XW];
        end
        2'd1: gmap_d = wr_data[GW-1:0];
        2'd2: begin
          if (!lock_q) begin
            spread_d = wr_data[0];
            lock_d   = wr_data[1];
          end
          pen_d  = wr_data[2];
          pidx_d = wr_data[8 +: IDX_W];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ymap_q   <= ID_Y[YW-1:0];
      xmap_q   <= ID_X[XW-1:0];
      gmap_q   <= ID_G[GW-1:0];
      spread_q <= 1'b0;
      lock_q   <= 1'b0;
      pen_q    <= 1'b0;
      pidx_q   <= '0;
    end else if (cfg_ce) begin
      ymap_q   <= ymap_d;
      xmap_q   <= xmap_d;
      gmap_q   <= gmap_d;
      spread_q <= spread_d;
      lock_q   <= lock_d;
      pen_q    <= pen_d;
      pidx_q   <= pidx_d;
    end
  end

  assign ymap      = ymap_q;
  assign xmap      = xmap_q;
  assign gmap      = gmap_q;
  assign spread    = spread_q;
  assign lock      = lock_q;
  assign promo_en  = pen_q;
  assign promo_idx = pidx_q;
endmodule

// File: rtl/irq_slot_owner.sv
module irq_slot_owner #(
  parameter int N  = 4,
  parameter int SW = 3
) (
  input  logic [N*SW-1:0] slots,
  input  logic [N-1:0]    req,
  output logic [N-1:0]    eff
);
  for (genvar i = 0; i < N; i++) begin : g_src
    logic taken;
    always_comb begin
      taken = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (slots[j*SW +: SW] == slots[i*SW +: SW]) taken = 1'b1;
      end
    end
    assign eff[i] = req[i] & ~taken;
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N  = 22,
  parameter int VW = 7,
  parameter int IW = 5
) (
  input  logic [N-1:0]    eff,
  input  logic [N*VW-1:0] lvl,
  input  logic            promo_en,
  input  logic [IW-1:0]   promo_idx,
  output logic [VW-1:0]   win_vec,
  output logic            win_any
);
  logic [VW-1:0] best;
  logic          hit;
  logic [VW-1:0] hit_lvl;

  always_comb begin
    best    = '1;
    win_any = 1'b0;
    hit     = 1'b0;
    hit_lvl = '0;
    for (int i = 0; i < N; i++) begin
      if (eff[i] && (lvl[i*VW +: VW] < best)) best = lvl[i*VW +: VW];
      win_any = win_any | eff[i];
      if (promo_en && (IW'(i) == promo_idx) && eff[i]) begin
        hit     = 1'b1;
        hit_lvl = lvl[i*VW +: VW];
      end
    end
    if (hit)          win_vec = hit_lvl;
    else if (win_any) win_vec = best;
    else              win_vec = '0;
  end
endmodule

// File: rtl/irq_prio_encoder.sv
module irq_prio_encoder
  import irq_prio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [NSRC-1:0]  req,
  output logic [VEC_W-1:0] vec,
  output logic             vec_vld
);
  logic [1:0]              rst_sync;
  logic                    rst_n_s;
  logic [NY*SLOT_W-1:0]    ymap;
  logic [NX*SLOT_W-1:0]    xmap;
  logic [NG*SLOT_W-1:0]    gmap;
  logic                    cfg_spread, cfg_lock, cfg_pen;
  logic [IDX_W-1:0]        cfg_pidx;
  logic [NY-1:0]           y_eff;
  logic [NX-1:0]           x_eff;
  logic [NG-1:0]           g_eff;
  logic [NSRC-1:0]         eff;
  logic [NSRC*VEC_W-1:0]   lvl;
  logic [VEC_W-1:0]        vec_d, vec_q;
  logic                    vld_d, vld_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  irq_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n_s), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ymap(ymap), .xmap(xmap), .gmap(gmap),
    .spread(cfg_spread), .lock(cfg_lock), .promo_en(cfg_pen),
    .promo_idx(cfg_pidx)
  );

  irq_slot_owner #(.N(NY), .SW(SLOT_W)) u_own_y (
    .slots(ymap), .req(req[Y_BASE +: NY]), .eff(y_eff));
  irq_slot_owner #(.N(NX), .SW(SLOT_W)) u_own_x (
    .slots(xmap), .req(req[X_BASE +: NX]), .eff(x_eff));
  irq_slot_owner #(.N(NG), .SW(SLOT_W)) u_own_g (
    .slots(gmap), .req(req[G_BASE +: NG]), .eff(g_eff));

  assign eff = {req[F_BASE +: NFIX], g_eff, x_eff, y_eff};

  for (genvar i = 0; i < NY; i++) begin : g_lvl_y
    assign lvl[(Y_BASE+i)*VEC_W +: VEC_W] =
      lvl_y(int'(ymap[i*SLOT_W +: SLOT_W]), cfg_spread);
  end
  for (genvar i = 0; i < NX; i++) begin : g_lvl_x
    assign lvl[(X_BASE+i)*VEC_W +: VEC_W] = lvl_x(int'(xmap[i*SLOT_W +: SLOT_W]));
  end
  for (genvar i = 0; i < NG; i++) begin : g_lvl_g
    assign lvl[(G_BASE+i)*VEC_W +: VEC_W] =
      lvl_n(int'(gmap[i*SLOT_W +: SLOT_W]), cfg_spread);
  end
  for (genvar i = 0; i < NFIX; i++) begin : g_lvl_f
    assign lvl[(F_BASE+i)*VEC_W +: VEC_W] = lvl_n(NSLOT + i, cfg_spread);
  end

  irq_pick #(.N(NSRC), .VW(VEC_W), .IW(IDX_W)) u_pick (
    .eff(eff), .lvl(lvl), .promo_en(cfg_pen), .promo_idx(cfg_pidx),
    .win_vec(vec_d), .win_any(vld_d)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      vec_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vec_q <= vec_d;
      vld_q <= vld_d;
    end
  end

  assign vec     = vec_q;
  assign vec_vld = vld_q;
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
  import irq_prio_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [NSRC-1:0]  req,
  input logic [VEC_W-1:0] vec,
  input logic             vec_vld,
  input logic             spread,
  input logic             lock
);
  localparam logic [NSRC-1:0] PIN0 = NSRC'(1) << (NSRC - 1);

  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> (!vec_vld && vec == '0));

  p_code_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vec_vld |-> (vec >= VEC_W'(1) && vec <= VEC_W'(MAX_LVL)));

  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);

  p_mode_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(spread));

  p_fixed_alive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req == PIN0) |=> vec_vld);
endmodule

bind irq_prio_encoder irq_prio_chk u_chk (
  .clk(clk), .rst_n(rst_n_s), .req(req), .vec(vec), .vec_vld(vec_vld),
  .spread(cfg_spread), .lock(cfg_lock)
);

// File: tb/sim_irq_prio_encoder.sv
module sim_irq_prio_encoder;
  localparam int CLK_P = 10;
  localparam int NS = 22;

  logic        clk, rst_n, wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic [21:0] req;
  logic [6:0]  vec;
  logic        vec_vld;

  int tests, fails;
  bit done;

  // bench shadow of programmed state
  int smap [15];
  bit sp, lk, pen;
  int pidx;

  irq_prio_encoder u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .req(req), .vec(vec), .vec_vld(vec_vld));

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic int lvl_of(int s);
    int m, j;
    if (s < 15) m = smap[s]; else m = 0;
    if (s < 4) return sp ? 9 + 2*m : 9 + m;
    if (s < 8) return 1 + m;
    if (s < 15) j = m; else j = 8 + (s - 15);
    if (sp && j < 8) return 10 + 2*j;
    return 17 + j;
  endfunction

  function automatic bit owns(int s);
    int lo;
    if (s >= 15) return 1'b1;
    lo = (s < 4) ? 0 : (s < 8) ? 4 : 8;
    for (int t = lo; t < s; t++) if (smap[t] == smap[s]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int exp_vec(logic [21:0] r);
    int best;
    best = 1000;
    if (pen && pidx < NS && r[pidx] && owns(pidx)) return lvl_of(pidx);
    for (int s = 0; s < NS; s++)
      if (r[s] && owns(s) && lvl_of(s) < best) best = lvl_of(s);
    return (best == 1000) ? 0 : best;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 2'd0) begin
      for (int k = 0; k < 4; k++) smap[k] = int'((d >> (3*k)) & 7);
      for (int k = 0; k < 4; k++) smap[4+k] = int'((d >> (12 + 3*k)) & 7);
    end else if (a == 2'd1) begin
      for (int k = 0; k < 7; k++) smap[8+k] = int'((d >> (3*k)) & 7);
    end else if (a == 2'd2) begin
      if (!lk) begin sp = d[0]; lk = d[1]; end
      pen = d[2]; pidx = int'(d[12:8]);
    end
  endtask

  task automatic chk(input string tag, input int ev);
    tests++;
    if (int'(vec) != ev || vec_vld != (ev != 0)) begin
      fails++;
      $display("FAIL %s: vec=%0d vld=%0b expected vec=%0d vld=%0b",
               tag, vec, vec_vld, ev, (ev != 0));
    end
  endtask

  task automatic apply(input string tag, input logic [21:0] r);
    req = r;
    @(negedge clk);
    chk(tag, exp_vec(r));
  endtask

  function automatic logic [31:0] mk_lo(int y0, int y1, int y2, int y3, int xoff);
    logic [31:0] d;
    d = 32'(y0) | (32'(y1) << 3) | (32'(y2) << 6) | (32'(y3) << 9);
    for (int k = 0; k < 4; k++) d = d | (32'((k + xoff) % 8) << (12 + 3*k));
    return d;
  endfunction

  initial begin
    done = 1'b0;
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: vec=%0d vld=%0b expected run to finish", vec, vec_vld);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tests = 0; fails = 0;
    for (int k = 0; k < 15; k++) smap[k] = (k < 4) ? k : (k < 8) ? k - 4 : k - 8;
    sp = 0; lk = 0; pen = 0; pidx = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; req = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 reset outputs", 0);
    apply("R9 identity Y1", 22'(1) << 1);

    for (int s = 0; s < NS; s++)
      apply((s >= 15) ? "R10 grouped fixed" : "R3 grouped single", 22'(1) << s);

    apply("R1 idle", '0);
    req = 22'(1) << 4;
    #1 chk("R1 not before edge", 0);
    @(negedge clk);
    chk("R1 one clock later", exp_vec(req));

    wr(2'd2, 32'h1);
    for (int s = 0; s < NS; s++)
      apply((s >= 15) ? "R10 spread fixed" : "R4 spread single", 22'(1) << s);
    apply("R4 spread all", '1);

    wr(2'd0, mk_lo(5, 5, 2, 3, 0));
    apply("R6 collision loser alone", 22'(1) << 1);
    apply("R6 collision owner", 22'b11);

    for (int st = 0; st < 8; st++) begin
      wr(2'd0, mk_lo(st % 8, (st + 1) % 8, (st + 2) % 8, (st + 3) % 8, st));
      apply("R5 rotate Y", 22'hF);
      apply("R5 rotate X", 22'hF0);
    end

    for (int it = 0; it < 200; it++) begin
      if (it % 3 == 0) wr(2'd0, $urandom);
      if (it % 5 == 0) wr(2'd1, $urandom);
      if (it % 4 == 0) apply("R2 random sparse", 22'($urandom) & 22'($urandom) & 22'($urandom));
      else             apply("R2 random", 22'($urandom));
    end

    wr(2'd0, mk_lo(0, 1, 2, 3, 0));
    wr(2'd2, 32'h1 | 32'h4 | (32'd21 << 8));
    apply("R8 promote pin0", '1);
    wr(2'd2, 32'h1 | 32'h4 | (32'd30 << 8));
    apply("R8 out-of-range index", '1);

    wr(2'd2, 32'h2);
    wr(2'd2, 32'h1);
    apply("R7 mode write ignored", 22'(1) << 1);
    wr(2'd2, 32'h1 | 32'h4 | (32'd8 << 8));
    apply("R7 promotion writable while locked", '1);
    apply("R7 still grouped", 22'(1) << 2);
    apply("R1 idle end", '0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule